// File: doc/BRIEF.md
# Tiled Surface Address Walker

This block turns a rectangular region of a 2D surface into a stream of byte offsets, one per element, for a memory that stores the surface in tiles. A controller sets the layout (linear or one of three 4 KB tile shapes), the row pitch, the element size, the region origin as a byte column and a row, the region width in elements and its height in rows, and whether bit 6 of the address gets the XOR swizzle. A one-cycle start pulse captures the settings. The block then walks the region row by row and presents each offset on a valid/ready stream, with a last flag on the final one.

The row-major tile numbering, the layout inside each tile shape and the swizzle are all done in hardware. A memory agent downstream consumes the offsets. Data movement, multi-slice strides and format conversion belong to other blocks.

Top module: `tile_addr_walker`

## Requirements
- R1: After reset, `out_valid`, `busy` and `done` are all low.
- R2: Layout code 0 (linear) gives the offset row*pitch + xbyte, and no swizzle is applied even when `cfg_swz` is high.
- R3: Layout code 1 uses 512-byte by 8-row tiles, with tiles_per_row = pitch/512. The offset is tile*4096 + (row mod 8)*512 + (xbyte mod 512), where tile = (row/8)*tiles_per_row + xbyte/512.
- R4: Layout code 2 uses 128-byte by 32-row tiles, with tiles_per_row = pitch/128 and 16-byte columns stored column-major. The offset is tile*4096 + ((xbyte mod 128)/16)*512 + (row mod 32)*16 + (xbyte mod 16).
- R5: Layout code 3 uses 64-byte by 64-row tiles, with tiles_per_row = pitch/64. Inside a tile, 8x8 blocks are stored column-major: b8 = ((xbyte mod 64)/8)*8 + (row mod 64)/8. Each 8x8 block holds 4x4, 2x2 and 1x1 levels indexed as (row bit k)*2 + (xbyte bit k) for k = 2, 1, 0. The offset is tile*4096 + b8*64 + b4*16 + b2*4 + b1.
- R6: With `cfg_swz` high in layout 1, output bit 6 is bit6 XOR bit9 XOR bit10 of the tiled offset.
- R7: With `cfg_swz` high in layouts 2 and 3, output bit 6 is bit6 XOR bit9 of the tiled offset.
- R8: Elements come out in row-major order. Within a row, xbyte starts at the origin and grows by `cfg_bpe` per element. After `cfg_width` elements the row goes up by one and xbyte returns to the origin, for `cfg_height` rows.
- R9: `out_last` is high only on the final element. `busy` stays high until that element is accepted, and `done` is a one-cycle pulse on the cycle after it is accepted.
- R10: While `out_valid` is high and `out_ready` is low, `out_addr` and `out_last` hold their values and the walk does not advance.
- R11: A `start` pulse while `busy` is high is ignored, and the stream in flight continues unchanged.
- R12: A start with zero width or zero height produces no element, leaves `busy` low, and pulses `done` on the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the configuration and begins a walk when idle |
| cfg_mode | input | 2 | Layout: 0 linear, 1 wide tile, 2 tall tile, 3 stencil tile |
| cfg_pitch | input | PW | Row pitch in bytes |
| cfg_bpe | input | BW | Bytes per element |
| cfg_swz | input | 1 | Enables the bit-6 swizzle |
| cfg_org_x | input | XW | Region origin as a byte column |
| cfg_org_y | input | YW | Region origin row |
| cfg_width | input | CW | Region width in elements |
| cfg_height | input | CW | Region height in rows |
| out_valid | output | 1 | An offset is presented |
| out_ready | input | 1 | The consumer accepts the offset |
| out_addr | output | AW | Tiled byte offset |
| out_last | output | 1 | Marks the final element of the region |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when the walk ends |

## Verification
The first offset appears two clock edges after the start edge: one edge arms the walker and the next loads the output register. After that, each accepted offset is replaced on the same edge that accepts it. `done` rises one edge after the last offset is accepted, or one edge after a zero-size start. The bench drives `out_ready` at the falling edge and samples there, so the element it compares is the one the next rising edge will accept. Expected offsets are computed from the formulas when the walk starts and kept in a queue. For backpressure, the values seen on one falling edge are compared with those on the next, and `done` pulses are counted over a window of a few cycles after the queue empties.

// File: rtl/tile_walk_pkg.sv
package tile_walk_pkg;
  typedef enum logic [1:0] {
    TM_LINEAR = 2'd0,
    TM_WIDE   = 2'd1,
    TM_TALL   = 2'd2,
    TM_STEN   = 2'd3
  } tmode_e;

  localparam int unsigned TILE_SHIFT = 12;
endpackage

// File: rtl/tw_box_walker.sv
module tw_box_walker #(
  parameter int XW = 16,
  parameter int YW = 16,
  parameter int CW = 16,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [XW-1:0] org_x,
  input  logic [YW-1:0] org_y,
  input  logic [BW-1:0] bpe,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic          adv,
  output logic          active,
  output logic [XW-1:0] xb,
  output logic [YW-1:0] row,
  output logic          is_last
);
  logic [XW-1:0] org_q;
  logic [BW-1:0] bpe_q;
  logic [CW-1:0] w_q, h_q, col, rc;
  logic          row_end;

  assign row_end = (col == w_q - 1'b1);
  assign is_last = row_end && (rc == h_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      org_q  <= '0;
      bpe_q  <= '0;
      w_q    <= '0;
      h_q    <= '0;
      col    <= '0;
      rc     <= '0;
      xb     <= '0;
      row    <= '0;
    end else if (load) begin
      active <= 1'b1;
      org_q  <= org_x;
      bpe_q  <= bpe;
      w_q    <= width;
      h_q    <= height;
      col    <= '0;
      rc     <= '0;
      xb     <= org_x;
      row    <= org_y;
    end else if (adv && active) begin
      if (is_last) begin
        active <= 1'b0;
      end else if (row_end) begin
        col <= '0;
        rc  <= rc + 1'b1;
        xb  <= org_q;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
        xb  <= xb + XW'(bpe_q);
      end
    end
  end

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && active && !is_last && !load) |=> (row == $past(row)) || (row == $past(row) + 1'b1)); // R8
endmodule

// File: rtl/tw_tile_map.sv
module tw_tile_map
  import tile_walk_pkg::*;
#(
  parameter int XW = 16,
  parameter int YW = 16,
  parameter int PW = 16,
  parameter int AW = 32
) (
  input  tmode_e        mode,
  input  logic [XW-1:0] xb,
  input  logic [YW-1:0] row,
  input  logic [PW-1:0] tpr,
  output logic [AW-1:0] off
);
  logic [AW-1:0] xa, ya, ta, tile;

  always_comb begin
    xa   = AW'(xb);
    ya   = AW'(row);
    ta   = AW'(tpr);
    tile = '0;
    off  = '0;
    unique case (mode)
      TM_LINEAR: off = ya * ta + xa;
      TM_WIDE: begin
        tile = (ya >> 3) * ta + (xa >> 9);
        off  = (tile << TILE_SHIFT) | (AW'(row[2:0]) << 9) | AW'(xb[8:0]);
      end
      TM_TALL: begin
        tile = (ya >> 5) * ta + (xa >> 7);
        off  = (tile << TILE_SHIFT) | (AW'(xb[6:4]) << 9)
             | (AW'(row[4:0]) << 4) | AW'(xb[3:0]);
      end
      TM_STEN: begin
        tile = (ya >> 6) * ta + (xa >> 6);
        off  = (tile << TILE_SHIFT) | (AW'(xb[5:3]) << 9) | (AW'(row[5:3]) << 6)
             | (AW'(row[2]) << 5) | (AW'(xb[2]) << 4)
             | (AW'(row[1]) << 3) | (AW'(xb[1]) << 2)
             | (AW'(row[0]) << 1) | AW'(xb[0]);
      end
      default: off = '0;
    endcase
  end
endmodule

// File: rtl/tw_swizzle.sv
module tw_swizzle
  import tile_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  tmode_e        mode,
  input  logic          en,
  input  logic [AW-1:0] raw,
  output logic [AW-1:0] sw
);
  always_comb begin
    sw = raw;
    if (en) begin
      unique case (mode)
        TM_WIDE:          sw[6] = raw[6] ^ raw[9] ^ raw[10];
        TM_TALL, TM_STEN: sw[6] = raw[6] ^ raw[9];
        default:          sw[6] = raw[6];
      endcase
    end
  end
endmodule

// File: rtl/tile_addr_walker.sv
module tile_addr_walker
  import tile_walk_pkg::*;
#(
  parameter int XW = 16,
  parameter int YW = 16,
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int BW = 5,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    cfg_mode,
  input  logic [PW-1:0] cfg_pitch,
  input  logic [BW-1:0] cfg_bpe,
  input  logic          cfg_swz,
  input  logic [XW-1:0] cfg_org_x,
  input  logic [YW-1:0] cfg_org_y,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_height,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_last,
  output logic          busy,
  output logic          done
);
  tmode_e        mode_q, mode_in;
  logic          swz_q;
  logic [PW-1:0] tpr_q, tpr_in;
  logic          take, empty_box, fire, gen_act, gen_last;
  logic [XW-1:0] cur_x;
  logic [YW-1:0] cur_y;
  logic [AW-1:0] raw_off, sw_off;

  assign mode_in   = tmode_e'(cfg_mode);
  assign busy      = gen_act || out_valid;
  assign take      = start && !busy;
  assign empty_box = (cfg_width == '0) || (cfg_height == '0);
  assign fire      = gen_act && (!out_valid || out_ready);

  always_comb begin
    unique case (mode_in)
      TM_WIDE: tpr_in = cfg_pitch >> 9;
      TM_TALL: tpr_in = cfg_pitch >> 7;
      TM_STEN: tpr_in = cfg_pitch >> 6;
      default: tpr_in = cfg_pitch;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TM_LINEAR;
      swz_q  <= 1'b0;
      tpr_q  <= '0;
    end else if (take) begin
      mode_q <= mode_in;
      swz_q  <= cfg_swz;
      tpr_q  <= tpr_in;
    end
  end

  tw_box_walker #(.XW(XW), .YW(YW), .CW(CW), .BW(BW)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .load   (take && !empty_box),
    .org_x  (cfg_org_x),
    .org_y  (cfg_org_y),
    .bpe    (cfg_bpe),
    .width  (cfg_width),
    .height (cfg_height),
    .adv    (fire),
    .active (gen_act),
    .xb     (cur_x),
    .row    (cur_y),
    .is_last(gen_last)
  );

  tw_tile_map #(.XW(XW), .YW(YW), .PW(PW), .AW(AW)) u_map (
    .mode(mode_q),
    .xb  (cur_x),
    .row (cur_y),
    .tpr (tpr_q),
    .off (raw_off)
  );

  tw_swizzle #(.AW(AW)) u_swz (
    .mode(mode_q),
    .en  (swz_q),
    .raw (raw_off),
    .sw  (sw_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= (take && empty_box) || (out_valid && out_ready && out_last);
      if (fire) begin
        out_valid <= 1'b1;
        out_addr  <= sw_off;
        out_last  <= gen_last;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_last))); // R10
  AST_LAST_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!out_valid && done && !busy)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mode_q) && $stable(tpr_q) && $stable(swz_q))); // R11
  AST_EMPTY_NOWORK: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && empty_box) |=> (!busy && done)); // R12
endmodule

// File: tb/tile_addr_walker_bench.sv
module tile_addr_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [15:0] cfg_pitch = '0;
  logic [4:0]  cfg_bpe = '0;
  logic        cfg_swz = 1'b0;
  logic [15:0] cfg_org_x = '0;
  logic [15:0] cfg_org_y = '0;
  logic [15:0] cfg_width = '0;
  logic [15:0] cfg_height = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic        out_last;
  logic        busy;
  logic        done;

  int total = 0;
  int bad = 0;
  int unsigned exp_q[$];

  always #4 clk = ~clk;

  tile_addr_walker u_tile_addr_walker (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_pitch(cfg_pitch),
    .cfg_bpe(cfg_bpe), .cfg_swz(cfg_swz), .cfg_org_x(cfg_org_x), .cfg_org_y(cfg_org_y),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_last(out_last), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned ref_off(int mode, int unsigned pitch, bit swz,
                                          int unsigned x, int unsigned y);
    int unsigned tpr, tile, o, b8, b4, b2, b1, bit6;
    case (mode)
      1: begin
        tpr = pitch / 512; tile = (y / 8) * tpr + x / 512;
        o = tile * 4096 + (y % 8) * 512 + x % 512;
      end
      2: begin
        tpr = pitch / 128; tile = (y / 32) * tpr + x / 128;
        o = tile * 4096 + ((x % 128) / 16) * 512 + (y % 32) * 16 + x % 16;
      end
      3: begin
        tpr = pitch / 64; tile = (y / 64) * tpr + x / 64;
        b8 = ((x % 64) / 8) * 8 + (y % 64) / 8;
        b4 = ((y / 4) % 2) * 2 + (x / 4) % 2;
        b2 = ((y / 2) % 2) * 2 + (x / 2) % 2;
        b1 = (y % 2) * 2 + x % 2;
        o = tile * 4096 + b8 * 64 + b4 * 16 + b2 * 4 + b1;
      end
      default: o = y * pitch + x;
    endcase
    if (swz && mode != 0) begin
      bit6 = ((o >> 6) ^ (o >> 9)) & 1;
      if (mode == 1) bit6 = bit6 ^ ((o >> 10) & 1);
      o = (o & ~32'd64) | (bit6 << 6);
    end
    return o;
  endfunction

  task automatic run_box(input int mode, input int pitch, input int bpe, input bit swz,
                         input int ox, input int oy, input int w, input int h,
                         input bit rnd_ready, input bit poke, input string req);
    int dcnt = 0;
    int tail = 0;
    int iter = 0;
    bit hold_pend = 0;
    logic [31:0] hold_addr = '0;
    logic hold_last = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        exp_q.push_back(ref_off(mode, pitch, swz, ox + c * bpe, oy + r));
    cfg_mode = mode[1:0]; cfg_pitch = pitch[15:0]; cfg_bpe = bpe[4:0]; cfg_swz = swz;
    cfg_org_x = ox[15:0]; cfg_org_y = oy[15:0]; cfg_width = w[15:0]; cfg_height = h[15:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (tail < 4 && iter < 5000) begin
      start = 1'b0;
      if (done) dcnt++;
      out_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
      if (hold_pend)
        check(out_valid && out_addr == hold_addr && out_last == hold_last, "R10",
              out_addr, hold_addr);
      if (out_valid && exp_q.size() == 0)
        check(1'b0, "R9 extra element", out_addr, 0);
      else if (out_valid && out_ready) begin
        check(out_addr == exp_q[0], {req, "/R8"}, out_addr, exp_q[0]);
        check(out_last == (exp_q.size() == 1), "R9 last", out_last, exp_q.size() == 1);
        void'(exp_q.pop_front());
      end
      hold_pend = out_valid && !out_ready;
      hold_addr = out_addr;
      hold_last = out_last;
      if (poke && iter == 2) begin
        check(busy == 1'b1, "R11 busy", busy, 1);
        cfg_mode = 2'd0; cfg_pitch = 16'd7; cfg_width = 16'd1; cfg_height = 16'd1;
        start = 1'b1;
      end
      if (exp_q.size() == 0) tail++;
      iter++;
      @(negedge clk);
    end
    start = 1'b0;
    check(dcnt == 1, "R9 done pulses", dcnt, 1);
    check(busy == 1'b0, "R9 idle", busy, 0);
    exp_q.delete();
  endtask

  task automatic run_empty(input int w, input int h);
    cfg_width = w[15:0]; cfg_height = h[15:0]; cfg_mode = 2'd1; cfg_pitch = 16'd2048;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R12 done", done, 1);
    check(busy == 1'b0 && out_valid == 1'b0, "R12 idle", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R12 pulse width", done, 0);
    check(out_valid == 1'b0, "R12 no element", out_valid, 0);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", {out_valid, busy, done}, 0);
    @(negedge clk);
    run_box(0, 256, 4, 1'b1, 8, 3, 5, 3, 1'b0, 1'b0, "R2");
    run_box(1, 2048, 4, 1'b0, 500, 6, 6, 4, 1'b1, 1'b0, "R3");
    run_box(1, 2048, 4, 1'b1, 500, 6, 6, 4, 1'b1, 1'b0, "R6");
    run_box(2, 512, 2, 1'b0, 120, 30, 8, 4, 1'b1, 1'b0, "R4");
    run_box(2, 512, 2, 1'b1, 120, 30, 8, 4, 1'b0, 1'b0, "R7");
    run_box(3, 256, 1, 1'b0, 60, 62, 8, 4, 1'b1, 1'b0, "R5");
    run_box(3, 256, 1, 1'b1, 60, 62, 8, 4, 1'b1, 1'b0, "R7");
    run_box(1, 1024, 16, 1'b1, 992, 7, 4, 3, 1'b1, 1'b1, "R11");
    run_box(2, 256, 4, 1'b0, 0, 0, 1, 1, 1'b0, 1'b0, "R8");
    run_empty(0, 5);
    run_empty(3, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule